// File: doc/BRIEF.md
# Direct-Mapped Split Cache with Isolation and Array Swap

This block is a pair of direct-mapped, write-through caches. One serves instruction fetches and the other serves data accesses. A processor issues one request at a time: a read or a write of one to four bytes at a byte address, marked as an instruction or a data access and optionally as uncached. When the block has finished the request, it pulses `rsp_done`. On reads the bytes are returned on `rsp_rdata`. A line-wide memory port with a request/acknowledge handshake carries line fills, write-backs of dirty victim lines, and write-through of stored bytes.

Two control inputs change how requests are routed. The swap input exchanges the two arrays, so that instruction requests use the data array and data requests use the instruction array. The isolate input confines data-side requests to the array: memory is never touched, and any isolated write invalidates the addressed line. This lets software probe and clear cache contents directly. A sticky miss flag records whether the most recent data read hit or missed.

Top module: `dm_cache_iso`

## Requirements
- R1: A request with length above 4 or with `req_uncached` set completes with `rsp_handled`=0. It causes no memory transaction and leaves `miss_flag` unchanged.
- R2: With `ctl_swap`=1 at request time, instruction requests use the data array and data requests use the instruction array. With `ctl_swap`=0, each request uses its own array.
- R3: With the default sizes, the line index is address bits [11:4] and the tag is address bits [31:12]. Two addresses that differ only above bit 11 occupy the same line.
- R4: A hit requires the line to be valid and its stored tag to equal the request tag. A non-isolated hit read causes no memory transaction.
- R5: `miss_flag` changes only on handled data-side reads, regardless of swap. It becomes 1 on a miss and 0 on a hit.
- R6: A data request made while `ctl_isolate`=1 never raises `mem_req`, whether it hits or misses. Instruction requests ignore `ctl_isolate`.
- R7: On a non-isolated miss whose victim is valid and dirty, a write-back (`mem_op`=1) of the victim line to address {old tag, index, 0} precedes a fill (`mem_op`=0) of the new line. A fill leaves the line valid with the new tag.
- R8: An isolated write clears the valid bit of the addressed line, so the next non-isolated access to that line misses.
- R9: A write sets the line's dirty bit only when at least one written byte differs from the byte the array holds. A line whose writes never changed a byte is not written back.
- R10: A handled, non-isolated write is passed to memory as a write-through (`mem_op`=2, with `mem_len` bytes at `mem_addr`). Reads and isolated accesses issue no write-through.
- R11: Byte i of a request occupies bits [8i+7:8i] of `req_wdata` and `rsp_rdata`. It is stored at array offset (address + i) modulo the cache size, so an access at the top of the array wraps to offset 0. Bytes at or above the length read as 0.
- R12: `mem_req`, `mem_op` and `mem_addr` stay stable until `mem_ack`. `rsp_done` is a one-cycle pulse that comes only after every memory transaction of the request has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_instr | input | 1 | 1 for an instruction-side request, 0 for data-side |
| req_write | input | 1 | 1 for write, 0 for read |
| req_uncached | input | 1 | Request bypasses the cache |
| req_len | input | 3 | Number of bytes |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write bytes, byte i in bits [8i+7:8i] |
| ctl_swap | input | 1 | Exchange instruction and data arrays |
| ctl_isolate | input | 1 | Confine data-side requests to the array |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_handled | output | 1 | Request was served by the cache |
| rsp_rdata | output | 32 | Read bytes |
| miss_flag | output | 1 | Miss status of the latest data read |
| mem_req | output | 1 | Memory transaction request |
| mem_op | output | 2 | 0 fill, 1 write-back, 2 write-through |
| mem_addr | output | 32 | Line address (fill/write-back) or byte address (write-through) |
| mem_len | output | 3 | Byte count of a write-through |
| mem_wdata | output | 8*LINE_BYTES | Victim line or write-through bytes in the low lanes |
| mem_rdata | input | 8*LINE_BYTES | Fill line from memory |
| mem_ack | input | 1 | Memory transaction complete |

## Verification
The embedded properties check several rules on every cycle: the memory request stays stable until acknowledged, a write-back is always followed directly by a fill, isolated requests never raise the memory request, and the miss flag holds across every request that is not a data read. They also check that a fill leaves the line valid and that an isolated write leaves it invalid. The scenario table covers behaviour that only shows over a sequence of requests. This includes the swap routing, dirty marking that depends on whether bytes changed, isolated writes that leave memory untouched, wrap-around at the top of the array, and the write-back address formed from the old tag.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W  = 32;
    localparam int MAX_LEN = 4;

    typedef enum logic [1:0] {
        MOP_FILL  = 2'd0,
        MOP_WBACK = 2'd1,
        MOP_WTHRU = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOK, ST_WBACK, ST_FILL, ST_ACCESS, ST_WTHRU, ST_RESP
    } state_e;

    typedef struct packed {
        logic              instr;
        logic              write;
        logic              uncached;
        logic [2:0]        len;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic              isolate;
    } req_t;

    function automatic logic is_bypass(req_t r);
        return r.uncached || (r.len > 3'(MAX_LEN));
    endfunction

endpackage

// File: rtl/dmc_tag_bank.sv
module dmc_tag_bank #(
    parameter int LINES = 256,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             dirty_en,
    input  logic             inval_en,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (set_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_en) dirty_q[idx] <= 1'b1;
            if (inval_en) valid_q[idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[idx] <= set_tag;
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
        set_en && !inval_en |=> valid_q[$past(idx)]); // R7
    AST_ISO_INVAL: assert property (@(posedge clk) disable iff (rst)
        inval_en |=> !valid_q[$past(idx)]); // R8

endmodule

// File: rtl/dmc_data_bank.sv
module dmc_data_bank #(
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_BYTES  = 16,
    localparam int OFF_W  = $clog2(CACHE_BYTES),
    localparam int LB_W   = $clog2(LINE_BYTES),
    localparam int IDX_W  = OFF_W - LB_W,
    localparam int LINES  = CACHE_BYTES / LINE_BYTES,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              byte_we,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [2:0]        byte_len,
    input  logic [31:0]       byte_wdata,
    output logic [LINE_W-1:0] line_out,
    output logic [31:0]       byte_rdata
);
    logic [LINE_W-1:0] arr_q [LINES];
    logic [OFF_W-1:0]  lane_off [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_off[g] = byte_off + OFF_W'(g);
        assign byte_rdata[8*g +: 8] =
            arr_q[lane_off[g][OFF_W-1:LB_W]][{lane_off[g][LB_W-1:0], 3'b000} +: 8];
    end

    always_ff @(posedge clk) begin
        if (fill_en) arr_q[line_idx] <= fill_line;
        if (byte_we) begin
            for (int i = 0; i < 4; i++) begin
                if (3'(i) < byte_len)
                    arr_q[lane_off[i][OFF_W-1:LB_W]][{lane_off[i][LB_W-1:0], 3'b000} +: 8]
                        <= byte_wdata[8*i +: 8];
            end
        end
    end

    assign line_out = arr_q[line_idx];

endmodule

// File: rtl/dm_cache_iso.sv
module dm_cache_iso
    import dmc_pkg::*;
#(
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_BYTES  = 16,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_instr,
    input  logic              req_write,
    input  logic              req_uncached,
    input  logic [2:0]        req_len,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              ctl_swap,
    input  logic              ctl_isolate,
    output logic              rsp_done,
    output logic              rsp_handled,
    output logic [31:0]       rsp_rdata,
    output logic              miss_flag,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [31:0]       mem_addr,
    output logic [2:0]        mem_len,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int OFF_W = $clog2(CACHE_BYTES);
    localparam int LB_W  = $clog2(LINE_BYTES);
    localparam int IDX_W = OFF_W - LB_W;
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int LINES = CACHE_BYTES / LINE_BYTES;

    state_e      state;
    req_t        q;
    logic        q_bank;      // 0 instruction array, 1 data array
    logic        handled_q, miss_q;
    logic [31:0] rdata_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             q_iso, q_dread, bypass, hit, differs;

    logic              bank_valid [2];
    logic              bank_dirty [2];
    logic [TAG_W-1:0]  bank_tag   [2];
    logic [LINE_W-1:0] bank_line  [2];
    logic [31:0]       bank_bytes [2];

    logic              sel_valid, sel_dirty;
    logic [TAG_W-1:0]  sel_tag;
    logic [LINE_W-1:0] sel_line;
    logic [31:0]       sel_bytes, rd_masked;

    assign idx     = q.addr[OFF_W-1:LB_W];
    assign tag     = q.addr[ADDR_W-1:OFF_W];
    assign q_iso   = !q.instr && q.isolate;
    assign q_dread = !q.instr && !q.write;
    assign bypass  = is_bypass(q);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic mine;
        assign mine = (q_bank == 1'(b));

        dmc_tag_bank #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
            .clk      (clk),
            .rst      (rst),
            .idx      (idx),
            .set_en   (mine && state == ST_FILL && mem_ack),
            .set_tag  (tag),
            .dirty_en (mine && state == ST_ACCESS && q.write && differs),
            .inval_en (mine && state == ST_ACCESS && q.write && q_iso),
            .rd_valid (bank_valid[b]),
            .rd_dirty (bank_dirty[b]),
            .rd_tag   (bank_tag[b])
        );

        dmc_data_bank #(.CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES)) u_data (
            .clk        (clk),
            .fill_en    (mine && state == ST_FILL && mem_ack),
            .line_idx   (idx),
            .fill_line  (mem_rdata),
            .byte_we    (mine && state == ST_ACCESS && q.write),
            .byte_off   (q.addr[OFF_W-1:0]),
            .byte_len   (q.len),
            .byte_wdata (q.wdata),
            .line_out   (bank_line[b]),
            .byte_rdata (bank_bytes[b])
        );
    end

    assign sel_valid = bank_valid[q_bank];
    assign sel_dirty = bank_dirty[q_bank];
    assign sel_tag   = bank_tag[q_bank];
    assign sel_line  = bank_line[q_bank];
    assign sel_bytes = bank_bytes[q_bank];
    assign hit       = sel_valid && (sel_tag == tag);

    always_comb begin
        differs   = 1'b0;
        rd_masked = '0;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < q.len) begin
                rd_masked[8*i +: 8] = sel_bytes[8*i +: 8];
                if (sel_bytes[8*i +: 8] != q.wdata[8*i +: 8]) differs = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            q         <= '0;
            q_bank    <= 1'b0;
            handled_q <= 1'b0;
            miss_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    q      <= '{instr: req_instr, write: req_write, uncached: req_uncached,
                                len: req_len, addr: req_addr, wdata: req_wdata,
                                isolate: ctl_isolate};
                    q_bank <= !req_instr ^ ctl_swap;
                    state  <= ST_LOOK;
                end
                ST_LOOK: begin
                    rdata_q <= '0;
                    if (bypass) begin
                        handled_q <= 1'b0;
                        state     <= ST_RESP;
                    end else begin
                        handled_q <= 1'b1;
                        if (q_dread) miss_q <= !hit;
                        if (!hit && !q_iso)
                            state <= (sel_valid && sel_dirty) ? ST_WBACK : ST_FILL;
                        else
                            state <= ST_ACCESS;
                    end
                end
                ST_WBACK: if (mem_ack) state <= ST_FILL;
                ST_FILL:  if (mem_ack) state <= ST_ACCESS;
                ST_ACCESS: begin
                    if (!q.write) rdata_q <= rd_masked;
                    state <= (q.write && !q_iso) ? ST_WTHRU : ST_RESP;
                end
                ST_WTHRU: if (mem_ack) state <= ST_RESP;
                ST_RESP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_op    = MOP_FILL;
        mem_addr  = '0;
        mem_len   = '0;
        mem_wdata = '0;
        unique case (state)
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WBACK;
                mem_addr  = {sel_tag, idx, {LB_W{1'b0}}};
                mem_wdata = sel_line;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_op   = MOP_FILL;
                mem_addr = {tag, idx, {LB_W{1'b0}}};
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WTHRU;
                mem_addr  = q.addr;
                mem_len   = q.len;
                mem_wdata = LINE_W'(q.wdata);
            end
            default: ;
        endcase
    end

    assign rsp_done    = (state == ST_RESP);
    assign rsp_handled = handled_q;
    assign rsp_rdata   = rdata_q;
    assign miss_flag   = miss_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R12
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_op) && $stable(mem_addr)); // R12
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_op == MOP_WBACK |=> mem_req && mem_op == MOP_FILL); // R7
    AST_ISO_QUIET: assert property (@(posedge clk) disable iff (rst)
        state != ST_IDLE && q_iso |-> !mem_req); // R6
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOOK && (bypass || !q_dread) |=> $stable(miss_flag)); // R5
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOOK && bypass |=> !mem_req && rsp_done && !rsp_handled); // R1

endmodule

// File: tb/sim_dm_cache_iso.sv
module sim_dm_cache_iso;
    localparam int LB = 16;
    localparam int LW = LB * 8;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_instr = 0, req_write = 0, req_uncached = 0;
    logic [2:0]  req_len = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic ctl_swap = 0, ctl_isolate = 0;
    logic rsp_done, rsp_handled, miss_flag, mem_req;
    logic [31:0] rsp_rdata, mem_addr;
    logic [1:0]  mem_op;
    logic [2:0]  mem_len;
    logic [LW-1:0] mem_wdata;
    logic [LW-1:0] mem_rdata = '0;
    logic mem_ack = 1'b0;

    always #10 clk = ~clk;

    dm_cache_iso u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_instr(req_instr),
        .req_write(req_write), .req_uncached(req_uncached), .req_len(req_len),
        .req_addr(req_addr), .req_wdata(req_wdata), .ctl_swap(ctl_swap),
        .ctl_isolate(ctl_isolate), .rsp_done(rsp_done), .rsp_handled(rsp_handled),
        .rsp_rdata(rsp_rdata), .miss_flag(miss_flag), .mem_req(mem_req),
        .mem_op(mem_op), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // backing store: byte at a starts as a[7:0] ^ a[12:8]
    logic [7:0] bmem [8192];
    int n_fill = 0, n_wb = 0, n_wt = 0;
    logic [31:0] last_wb_addr = '0;
    int n_chk = 0, n_bad = 0;

    initial begin
        for (int a = 0; a < 8192; a++) bmem[a] = 8'(a) ^ {3'b000, 5'(a >> 8)};
    end

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack = 1'b1;
                case (mem_op)
                    2'd0: begin
                        for (int i = 0; i < LB; i++) mem_rdata[8*i +: 8] = bmem[13'(mem_addr + 32'(i))];
                        n_fill++;
                    end
                    2'd1: begin
                        for (int i = 0; i < LB; i++) bmem[13'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
                        n_wb++;
                        last_wb_addr = mem_addr;
                    end
                    default: begin
                        for (int i = 0; i < 4; i++)
                            if (i < int'(mem_len)) bmem[13'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
                        n_wt++;
                    end
                endcase
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        instr, wr, unc;
        logic [2:0]  len;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        swap, iso, chk_rd;
        logic [31:0] exp_rd;
        logic        hdl, miss;
        logic [1:0]  dfill, dwb, dwt;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h43424140,1'b1,1'b1,2'd1,2'd0,2'd0}, // R4 cold miss
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h43424140,1'b1,1'b0,2'd0,2'd0,2'd0}, // R4 R5 hit
        '{1'b0,1'b1,1'b0,3'd2,16'h0040,32'h0000BBAA,1'b0,1'b0,1'b0,32'h0,       1'b1,1'b0,2'd0,2'd0,2'd1}, // R10 R9
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h4342BBAA,1'b1,1'b0,2'd0,2'd0,2'd0}, // R11
        '{1'b0,1'b0,1'b0,3'd4,16'h1040,32'h0,       1'b0,1'b0,1'b1,32'h53525150,1'b1,1'b1,2'd1,2'd1,2'd0}, // R3 R7
        '{1'b0,1'b1,1'b0,3'd4,16'h1040,32'h53525150,1'b0,1'b0,1'b0,32'h0,       1'b1,1'b1,2'd0,2'd0,2'd1}, // R9 same bytes
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h4342BBAA,1'b1,1'b1,2'd1,2'd0,2'd0}, // R9 clean victim
        '{1'b1,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h4342BBAA,1'b1,1'b1,2'd1,2'd0,2'd0}, // R5 instr read
        '{1'b0,1'b0,1'b0,3'd4,16'h1040,32'h0,       1'b0,1'b0,1'b1,32'h53525150,1'b1,1'b1,2'd1,2'd0,2'd0}, // R2 setup
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b1,1'b0,1'b1,32'h4342BBAA,1'b1,1'b0,2'd0,2'd0,2'd0}, // R2 data->instr array
        '{1'b1,1'b0,1'b0,3'd4,16'h1040,32'h0,       1'b1,1'b0,1'b1,32'h53525150,1'b1,1'b0,2'd0,2'd0,2'd0}, // R2 instr->data array
        '{1'b0,1'b1,1'b0,3'd1,16'h0040,32'h00000077,1'b0,1'b1,1'b0,32'h0,       1'b1,1'b0,2'd0,2'd0,2'd0}, // R6 R8 iso write
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b1,1'b1,32'h53525177,1'b1,1'b1,2'd0,2'd0,2'd0}, // R6 iso read miss
        '{1'b0,1'b0,1'b0,3'd4,16'h1040,32'h0,       1'b0,1'b0,1'b1,32'h53525150,1'b1,1'b1,2'd1,2'd0,2'd0}, // R8 invalid line
        '{1'b0,1'b0,1'b0,3'd5,16'h0040,32'h0,       1'b0,1'b0,1'b0,32'h0,       1'b0,1'b1,2'd0,2'd0,2'd0}, // R1 long
        '{1'b0,1'b1,1'b1,3'd4,16'h0040,32'hDEADBEEF,1'b0,1'b0,1'b0,32'h0,       1'b0,1'b1,2'd0,2'd0,2'd0}, // R1 uncached
        '{1'b0,1'b0,1'b0,3'd4,16'h0040,32'h0,       1'b0,1'b0,1'b1,32'h4342BBAA,1'b1,1'b1,2'd1,2'd0,2'd0}, // R1 mem untouched
        '{1'b0,1'b0,1'b0,3'd4,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h03020100,1'b1,1'b1,2'd1,2'd0,2'd0}, // R11 setup
        '{1'b0,1'b0,1'b0,3'd4,16'h0FFE,32'h0,       1'b0,1'b0,1'b1,32'h0100F0F1,1'b1,1'b1,2'd1,2'd0,2'd0}  // R11 wrap
    };

    task automatic issue(input vec_t v, output logic ok);
        int guard = 0;
        @(negedge clk);
        req_valid = 1; req_instr = v.instr; req_write = v.wr; req_uncached = v.unc;
        req_len = v.len; req_addr = {16'h0, v.addr}; req_wdata = v.wdata;
        ctl_swap = v.swap; ctl_isolate = v.iso;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        ok = rsp_done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ok;
        int f0, w0, t0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!rsp_done, "R12 reset done", 32'(rsp_done), 0);
        chk(!miss_flag, "R5 reset miss", 32'(miss_flag), 0);
        chk(!mem_req, "R12 reset mem_req", 32'(mem_req), 0);

        for (int k = 0; k < NV; k++) begin
            f0 = n_fill; w0 = n_wb; t0 = n_wt;
            issue(VECS[k], ok);
            chk(ok, $sformatf("R12 v%0d done", k), 32'(ok), 1);
            chk(rsp_handled == VECS[k].hdl, $sformatf("R1 v%0d handled", k), 32'(rsp_handled), 32'(VECS[k].hdl));
            chk(miss_flag == VECS[k].miss, $sformatf("R5 v%0d miss", k), 32'(miss_flag), 32'(VECS[k].miss));
            if (VECS[k].chk_rd)
                chk(rsp_rdata == VECS[k].exp_rd, $sformatf("R11 v%0d rdata", k), rsp_rdata, VECS[k].exp_rd);
            chk(n_fill - f0 == int'(VECS[k].dfill), $sformatf("R4 v%0d fills", k), 32'(n_fill - f0), 32'(VECS[k].dfill));
            chk(n_wb - w0 == int'(VECS[k].dwb), $sformatf("R7 v%0d writebacks", k), 32'(n_wb - w0), 32'(VECS[k].dwb));
            chk(n_wt - t0 == int'(VECS[k].dwt), $sformatf("R10 v%0d writethrough", k), 32'(n_wt - t0), 32'(VECS[k].dwt));
            @(negedge clk);
            chk(!rsp_done, $sformatf("R12 v%0d pulse", k), 32'(rsp_done), 0);
        end

        // R7 write-back went to {old tag, index}
        chk(last_wb_addr == 32'h40, "R7 wb address", last_wb_addr, 32'h40);
        // R6 isolated write left memory unchanged
        chk(bmem[13'h1040] == 8'h50, "R6 memory byte", 32'(bmem[13'h1040]), 32'h50);

        // R4 reset clears valid: a previously cached line misses again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(!miss_flag, "R5 miss after reset", 32'(miss_flag), 0);
        f0 = n_fill;
        issue('{1'b0,1'b0,1'b0,3'd4,16'h0000,32'h0,1'b0,1'b0,1'b1,32'h03020100,1'b1,1'b1,2'd1,2'd0,2'd0}, ok);
        chk(miss_flag, "R4 miss after reset", 32'(miss_flag), 1);
        chk(n_fill - f0 == 1, "R4 refill after reset", 32'(n_fill - f0), 1);
        chk(rsp_rdata == 32'h03020100, "R11 refill data", rsp_rdata, 32'h03020100);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule